// File: doc/BRIEF.md
# Home-Node Coherence Directory (MSI)

This block is the home node for a group of private caches that keep lines in Modified, Shared or Invalid state. For each line address it keeps a directory entry with a line state (Uncached, Shared or Exclusive) and an exact bit-vector with one bit per cache. Caches send it shared-read, exclusive-write and writeback requests. When holders must give up or reduce their copies, it sends invalidations or downgrades only to the caches whose bits are set. It counts the replies and only then answers the requester with a grant or a writeback acknowledgement. Line data is held in a small internal memory array that updates when an owner returns dirty data.

Requests enter through a small in-order queue, and a single transaction engine serves them one at a time. A request that arrives while an earlier transaction is still collecting snoop replies waits in the queue and is served after that transaction completes. Outgoing messages (grants, acknowledgements, invalidations, downgrades) share one valid/ready channel. Snoop replies from the caches come back on a separate channel that is always accepted.

Top module: `coh_directory`

## Requirements
- R1: After reset every line is Uncached with an empty sharer vector, memory line `a` holds the value `a`, `req_ready` is 1 and `out_valid` is 0.
- R2: A shared request (`req_kind` 0) to an Uncached or Shared line sends no snoop. It adds the requester to the sharers, leaves the line Shared and answers with a shared grant (`out_kind` 0) to the requester that carries the line's memory data.
- R3: A shared request to an Exclusive line sends one downgrade (`out_kind` 4) to the owner. The grant's data is the data returned in the owner's reply (`snp_has_data` 1), which is also written to memory. The line then becomes Shared with owner and requester as sharers.
- R4: An exclusive request (`req_kind` 1) sends one invalidation (`out_kind` 3) to every recorded holder except the requester and to no other cache. It then answers with an exclusive grant (`out_kind` 1) and leaves the requester as the sole owner. A reply carrying data replaces the grant data and memory.
- R5: A grant is never issued before every snoop reply of that transaction has arrived. A per-transaction counter of outstanding replies must first reach zero, however long the replies are delayed.
- R6: A writeback (`req_kind` 2) from a sharer of a Shared line removes that sharer and leaves memory unchanged. If it was the last sharer, the line becomes Uncached. The request is answered with an acknowledgement (`out_kind` 2, data 0).
- R7: A writeback from the owner of an Exclusive line writes its data to memory and returns the line to Uncached with no sharers. It is acknowledged.
- R8: A writeback from a cache that is not a recorded holder is acknowledged and changes neither the directory entry nor memory.
- R9: Requests are served in arrival order. `req_ready` stays 1 while a transaction is in progress as long as the queue has room, so a second and third request can be queued behind a busy line.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outgoing message holds its kind, line, destination and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when both high |
| req_kind | input | 2 | 0 shared, 1 exclusive, 2 writeback |
| req_line | input | LINE_W | Line address |
| req_src | input | ID_W | Requesting cache |
| req_data | input | DATA_W | Writeback data |
| snp_valid | input | 1 | Snoop reply from a cache (always accepted) |
| snp_src | input | ID_W | Cache sending the reply |
| snp_has_data | input | 1 | Reply carries dirty data |
| snp_data | input | DATA_W | Returned data |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Outgoing message accepted when both high |
| out_kind | output | 3 | 0 shared grant, 1 exclusive grant, 2 ack, 3 invalidate, 4 downgrade |
| out_line | output | LINE_W | Line address of the message |
| out_dest | output | ID_W | Destination cache |
| out_data | output | DATA_W | Grant data (0 for ack and snoops) |

## Verification
The hardest situation to reach is a queued request that arrives while an earlier transaction on the same line is still waiting for its snoop replies. The queued request must then see the directory entry the first one leaves behind. The bench sends two requests back to back and holds the invalidation replies back for several cycles. It then checks that no grant appears early and that the second request's downgrade goes to the newly granted owner. Since the directory state cannot be read out, each state is inferred from the exact set of snoops the next request produces.

// File: rtl/coh_pkg.sv
// Shared encodings for the coherence directory.
// Assumes: message kinds fixed as listed; widths are set by the top.
package coh_pkg;

    typedef enum logic [1:0] {
        RQ_SHARED = 2'd0,
        RQ_EXCL   = 2'd1,
        RQ_WB     = 2'd2,
        RQ_RSVD   = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        MSG_SH_GRANT  = 3'd0,
        MSG_EX_GRANT  = 3'd1,
        MSG_WB_ACK    = 3'd2,
        MSG_INVAL     = 3'd3,
        MSG_DOWNGRADE = 3'd4
    } msg_kind_e;

    typedef enum logic [1:0] {
        LN_UNCACHED = 2'd0,
        LN_SHARED   = 2'd1,
        LN_EXCL     = 2'd2
    } line_state_e;

endpackage

// File: rtl/coh_req_fifo.sv
// In-order request queue in front of the transaction engine.
// Assumes: DEPTH >= 2; payload is an opaque packed vector.
module coh_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_nonempty,
    input  logic             out_pop,
    output logic [WIDTH-1:0] out_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             push;

    assign in_ready     = (count_q != CNT_W'(DEPTH));
    assign out_nonempty = (count_q != '0);
    assign push         = in_valid && in_ready;
    assign out_data     = slots_q[rd_ptr_q];

    // Store the incoming payload in the write slot.
    always_ff @(posedge clk) begin
        if (push) slots_q[wr_ptr_q] <= in_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push)
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (out_pop)
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            count_q <= count_q + CNT_W'(push) - CNT_W'(out_pop);
        end
    end

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_pop |-> out_nonempty); // R9

endmodule

// File: rtl/coh_dir_store.sv
// Directory entries and line memory, one entry per line address.
// Assumes: one read port (combinational), one entry write and one data write per cycle.
module coh_dir_store
    import coh_pkg::*;
#(
    parameter int N_CACHES = 4,
    parameter int LINES    = 16,
    parameter int DATA_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_line,
    output line_state_e              rd_state,
    output logic [N_CACHES-1:0]      rd_sharers,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     dir_we,
    input  logic [$clog2(LINES)-1:0] dir_wr_line,
    input  line_state_e              dir_wr_state,
    input  logic [N_CACHES-1:0]      dir_wr_sharers,
    input  logic                     mem_we,
    input  logic [$clog2(LINES)-1:0] mem_wr_line,
    input  logic [DATA_W-1:0]        mem_wr_data
);
    line_state_e         state_q   [LINES];
    logic [N_CACHES-1:0] sharers_q [LINES];
    logic [DATA_W-1:0]   mem_q     [LINES];

    assign rd_state   = state_q[rd_line];
    assign rd_sharers = sharers_q[rd_line];
    assign rd_data    = mem_q[rd_line];

    // Reset all entries to Uncached, write back engine updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                state_q[i]   <= LN_UNCACHED;
                sharers_q[i] <= '0;
            end
        end else if (dir_we) begin
            state_q[dir_wr_line]   <= dir_wr_state;
            sharers_q[dir_wr_line] <= dir_wr_sharers;
        end
    end

    // Line memory: initialised to its own index, written with dirty data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem_q[i] <= DATA_W'(i);
        end else if (mem_we) begin
            mem_q[mem_wr_line] <= mem_wr_data;
        end
    end

    AST_EX_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we && dir_wr_state == LN_EXCL |-> $countones(dir_wr_sharers) == 1); // R4
    AST_UNCACHED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we && dir_wr_state == LN_UNCACHED |-> dir_wr_sharers == '0); // R6

endmodule

// File: rtl/coh_pick_lowest.sv
// Selects the lowest set bit of a mask as one-hot and as an index.
// Assumes: result is don't-care when the mask is empty (any = 0).
module coh_pick_lowest #(
    parameter int N = 4
) (
    input  logic [N-1:0]         mask,
    output logic [N-1:0]         onehot,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        onehot = '0;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                onehot = '0;
                onehot[i] = 1'b1;
                idx = $clog2(N)'(i);
            end
        end
        any = |mask;
    end

endmodule

// File: rtl/coh_engine.sv
// Transaction engine: decides the directory action for one request,
// multicasts snoops to recorded holders, counts replies, then grants.
// Assumes: only one transaction is live; snoop replies only come for
// snoops of the live transaction and are always accepted.
module coh_engine
    import coh_pkg::*;
#(
    parameter int N_CACHES = 4,
    parameter int LINES    = 16,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hd_valid,
    input  logic [1:0]                  hd_kind,
    input  logic [$clog2(LINES)-1:0]    hd_line,
    input  logic [$clog2(N_CACHES)-1:0] hd_src,
    input  logic [DATA_W-1:0]           hd_data,
    output logic                        hd_pop,
    output logic [$clog2(LINES)-1:0]    dir_rd_line,
    input  line_state_e                 dir_rd_state,
    input  logic [N_CACHES-1:0]         dir_rd_sharers,
    input  logic [DATA_W-1:0]           mem_rd_data,
    output logic                        dir_we,
    output logic [$clog2(LINES)-1:0]    dir_wr_line,
    output line_state_e                 dir_wr_state,
    output logic [N_CACHES-1:0]         dir_wr_sharers,
    output logic                        mem_we,
    output logic [$clog2(LINES)-1:0]    mem_wr_line,
    output logic [DATA_W-1:0]           mem_wr_data,
    input  logic                        snp_valid,
    input  logic [$clog2(N_CACHES)-1:0] snp_src,
    input  logic                        snp_has_data,
    input  logic [DATA_W-1:0]           snp_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [2:0]                  out_kind,
    output logic [$clog2(LINES)-1:0]    out_line,
    output logic [$clog2(N_CACHES)-1:0] out_dest,
    output logic [DATA_W-1:0]           out_data
);
    localparam int ID_W   = $clog2(N_CACHES);
    localparam int LINE_W = $clog2(LINES);
    localparam int PEND_W = $clog2(N_CACHES + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_SNOOP, PH_GRANT} phase_e;

    phase_e              phase_q;
    req_kind_e           t_kind_q;
    logic [LINE_W-1:0]   t_line_q;
    logic [ID_W-1:0]     t_src_q;
    logic [DATA_W-1:0]   t_data_q;
    line_state_e         nx_state_q;
    logic [N_CACHES-1:0] nx_sharers_q;
    logic [N_CACHES-1:0] to_send_q;
    logic [N_CACHES-1:0] holders_q;
    logic [PEND_W-1:0]   pend_q;
    logic                wb_commit_q;

    req_kind_e           hd_kind_e;
    logic [N_CACHES-1:0] req_bit, others;
    line_state_e         d_state;
    logic [N_CACHES-1:0] d_sharers, d_targets;
    logic                d_wb;

    logic [N_CACHES-1:0] pick_onehot;
    logic [ID_W-1:0]     pick_idx;
    logic                pick_any;
    logic [N_CACHES-1:0] send_next;
    logic [PEND_W-1:0]   pend_next;
    logic                snoop_fire;

    // Count set bits of a holder mask.
    function automatic logic [PEND_W-1:0] count_bits(input logic [N_CACHES-1:0] m);
        logic [PEND_W-1:0] c;
        c = '0;
        for (int i = 0; i < N_CACHES; i++) c = c + PEND_W'(m[i]);
        return c;
    endfunction

    assign hd_kind_e   = req_kind_e'(hd_kind);
    assign dir_rd_line = hd_line;
    assign req_bit     = N_CACHES'(1) << hd_src;
    assign others      = dir_rd_sharers & ~req_bit;

    // Decide next entry, snoop targets and memory commit for the head request.
    always_comb begin
        d_state   = dir_rd_state;
        d_sharers = dir_rd_sharers;
        d_targets = '0;
        d_wb      = 1'b0;
        unique case (hd_kind_e)
            RQ_SHARED: begin
                d_state   = LN_SHARED;
                d_sharers = (dir_rd_state == LN_UNCACHED) ? req_bit : (dir_rd_sharers | req_bit);
                d_targets = (dir_rd_state == LN_EXCL) ? others : '0;
            end
            RQ_EXCL: begin
                d_state   = LN_EXCL;
                d_sharers = req_bit;
                d_targets = (dir_rd_state == LN_UNCACHED) ? '0 : others;
            end
            default: begin
                if (dir_rd_state != LN_UNCACHED && dir_rd_sharers[hd_src] && hd_kind_e == RQ_WB) begin
                    d_sharers = others;
                    d_state   = (dir_rd_state == LN_EXCL || others == '0) ? LN_UNCACHED : LN_SHARED;
                    d_wb      = (dir_rd_state == LN_EXCL);
                end
            end
        endcase
    end

    coh_pick_lowest #(.N(N_CACHES)) u_pick (
        .mask   (to_send_q),
        .onehot (pick_onehot),
        .idx    (pick_idx),
        .any    (pick_any)
    );

    assign snoop_fire = (phase_q == PH_SNOOP) && pick_any && out_ready;
    assign send_next  = snoop_fire ? (to_send_q & ~pick_onehot) : to_send_q;
    assign pend_next  = pend_q - PEND_W'(snp_valid);
    assign hd_pop     = (phase_q == PH_IDLE) && hd_valid;

    // Transaction sequencing: latch, snoop and count, grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            t_kind_q     <= RQ_SHARED;
            t_line_q     <= '0;
            t_src_q      <= '0;
            t_data_q     <= '0;
            nx_state_q   <= LN_UNCACHED;
            nx_sharers_q <= '0;
            to_send_q    <= '0;
            holders_q    <= '0;
            pend_q       <= '0;
            wb_commit_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (hd_valid) begin
                        t_kind_q     <= hd_kind_e;
                        t_line_q     <= hd_line;
                        t_src_q      <= hd_src;
                        t_data_q     <= (hd_kind_e == RQ_WB) ? hd_data : mem_rd_data;
                        nx_state_q   <= d_state;
                        nx_sharers_q <= d_sharers;
                        to_send_q    <= d_targets;
                        holders_q    <= d_targets;
                        pend_q       <= count_bits(d_targets);
                        wb_commit_q  <= d_wb;
                        phase_q      <= (d_targets != '0) ? PH_SNOOP : PH_GRANT;
                    end
                end
                PH_SNOOP: begin
                    to_send_q <= send_next;
                    pend_q    <= pend_next;
                    if (snp_valid && snp_has_data) t_data_q <= snp_data;
                    if (send_next == '0 && pend_next == '0) phase_q <= PH_GRANT;
                end
                default: begin
                    if (out_ready) phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Drive the outgoing message for the current phase.
    always_comb begin
        out_valid = 1'b0;
        out_kind  = MSG_WB_ACK;
        out_line  = t_line_q;
        out_dest  = t_src_q;
        out_data  = '0;
        if (phase_q == PH_SNOOP) begin
            out_valid = pick_any;
            out_kind  = (t_kind_q == RQ_SHARED) ? MSG_DOWNGRADE : MSG_INVAL;
            out_dest  = pick_idx;
        end else if (phase_q == PH_GRANT) begin
            out_valid = 1'b1;
            unique case (t_kind_q)
                RQ_SHARED: begin out_kind = MSG_SH_GRANT; out_data = t_data_q; end
                RQ_EXCL:   begin out_kind = MSG_EX_GRANT; out_data = t_data_q; end
                default:   out_kind = MSG_WB_ACK;
            endcase
        end
    end

    // Directory and memory write ports.
    always_comb begin
        dir_we         = (phase_q == PH_GRANT) && out_ready;
        dir_wr_line    = t_line_q;
        dir_wr_state   = nx_state_q;
        dir_wr_sharers = nx_sharers_q;
        mem_wr_line    = t_line_q;
        if (phase_q == PH_SNOOP) begin
            mem_we      = snp_valid && snp_has_data;
            mem_wr_data = snp_data;
        end else begin
            mem_we      = (phase_q == PH_GRANT) && out_ready && wb_commit_q;
            mem_wr_data = t_data_q;
        end
    end

    AST_GRANT_AFTER_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind < 3'd3 |-> pend_q == '0 && to_send_q == '0); // R5
    AST_REPLY_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> phase_q == PH_SNOOP && pend_q != '0 && holders_q[snp_src]); // R5
    AST_SNOOP_NOT_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind >= 3'd3 |-> out_dest != t_src_q); // R4

endmodule

// File: rtl/coh_directory.sv
// Top of the home-node MSI directory: request queue, transaction engine,
// directory/memory store.
// Assumes: caches answer every snoop exactly once on the snoop channel.
module coh_directory
    import coh_pkg::*;
#(
    parameter int N_CACHES   = 4,
    parameter int LINES      = 16,
    parameter int DATA_W     = 32,
    parameter int QUEUE_SIZE = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [1:0]                  req_kind,
    input  logic [$clog2(LINES)-1:0]    req_line,
    input  logic [$clog2(N_CACHES)-1:0] req_src,
    input  logic [DATA_W-1:0]           req_data,
    input  logic                        snp_valid,
    input  logic [$clog2(N_CACHES)-1:0] snp_src,
    input  logic                        snp_has_data,
    input  logic [DATA_W-1:0]           snp_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [2:0]                  out_kind,
    output logic [$clog2(LINES)-1:0]    out_line,
    output logic [$clog2(N_CACHES)-1:0] out_dest,
    output logic [DATA_W-1:0]           out_data
);
    localparam int ID_W   = $clog2(N_CACHES);
    localparam int LINE_W = $clog2(LINES);
    localparam int REQ_W  = 2 + LINE_W + ID_W + DATA_W;

    logic [REQ_W-1:0]    hd_bits;
    logic                hd_valid, hd_pop;
    logic [1:0]          hd_kind;
    logic [LINE_W-1:0]   hd_line;
    logic [ID_W-1:0]     hd_src;
    logic [DATA_W-1:0]   hd_data;

    logic [LINE_W-1:0]   rd_line;
    line_state_e         rd_state;
    logic [N_CACHES-1:0] rd_sharers;
    logic [DATA_W-1:0]   rd_data;
    logic                dir_we, mem_we;
    logic [LINE_W-1:0]   dir_wr_line, mem_wr_line;
    line_state_e         dir_wr_state;
    logic [N_CACHES-1:0] dir_wr_sharers;
    logic [DATA_W-1:0]   mem_wr_data;

    coh_req_fifo #(.WIDTH(REQ_W), .DEPTH(QUEUE_SIZE)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (req_valid),
        .in_ready     (req_ready),
        .in_data      ({req_kind, req_line, req_src, req_data}),
        .out_nonempty (hd_valid),
        .out_pop      (hd_pop),
        .out_data     (hd_bits)
    );

    assign {hd_kind, hd_line, hd_src, hd_data} = hd_bits;

    coh_dir_store #(.N_CACHES(N_CACHES), .LINES(LINES), .DATA_W(DATA_W)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_line        (rd_line),
        .rd_state       (rd_state),
        .rd_sharers     (rd_sharers),
        .rd_data        (rd_data),
        .dir_we         (dir_we),
        .dir_wr_line    (dir_wr_line),
        .dir_wr_state   (dir_wr_state),
        .dir_wr_sharers (dir_wr_sharers),
        .mem_we         (mem_we),
        .mem_wr_line    (mem_wr_line),
        .mem_wr_data    (mem_wr_data)
    );

    coh_engine #(.N_CACHES(N_CACHES), .LINES(LINES), .DATA_W(DATA_W)) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .hd_valid       (hd_valid),
        .hd_kind        (hd_kind),
        .hd_line        (hd_line),
        .hd_src         (hd_src),
        .hd_data        (hd_data),
        .hd_pop         (hd_pop),
        .dir_rd_line    (rd_line),
        .dir_rd_state   (rd_state),
        .dir_rd_sharers (rd_sharers),
        .mem_rd_data    (rd_data),
        .dir_we         (dir_we),
        .dir_wr_line    (dir_wr_line),
        .dir_wr_state   (dir_wr_state),
        .dir_wr_sharers (dir_wr_sharers),
        .mem_we         (mem_we),
        .mem_wr_line    (mem_wr_line),
        .mem_wr_data    (mem_wr_data),
        .snp_valid      (snp_valid),
        .snp_src        (snp_src),
        .snp_has_data   (snp_has_data),
        .snp_data       (snp_data),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_kind       (out_kind),
        .out_line       (out_line),
        .out_dest       (out_dest),
        .out_data       (out_data)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_line)
            && $stable(out_dest) && $stable(out_data)); // R10

endmodule

// File: tb/coh_directory_bench.sv
// Directed bench: one task per scenario, each checks its own results.
module coh_directory_bench;
    localparam int NC = 4;
    localparam int NL = 16;
    localparam int DW = 32;
    localparam logic [2:0] K_SHG = 3'd0, K_EXG = 3'd1, K_ACK = 3'd2, K_INV = 3'd3, K_DWN = 3'd4;
    localparam logic [1:0] Q_SH = 2'd0, Q_EX = 2'd1, Q_WB = 2'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [3:0]    req_line = '0;
    logic [1:0]    req_src = '0;
    logic [DW-1:0] req_data = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_src = '0;
    logic          snp_has_data = 1'b0;
    logic [DW-1:0] snp_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [2:0]    out_kind;
    logic [3:0]    out_line;
    logic [1:0]    out_dest;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    coh_directory #(.N_CACHES(NC), .LINES(NL), .DATA_W(DW), .QUEUE_SIZE(4)) u_coh_directory (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_line(req_line), .req_src(req_src), .req_data(req_data),
        .snp_valid(snp_valid), .snp_src(snp_src), .snp_has_data(snp_has_data), .snp_data(snp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_line(out_line), .out_dest(out_dest), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [1:0] k, input logic [3:0] ln, input logic [1:0] src, input logic [DW-1:0] d);
        @(negedge clk);
        req_kind = k; req_line = ln; req_src = src; req_data = d; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // Accept messages until the grant; answer snoops after 'hold' cycles.
    task automatic collect(input string tag, input logic [3:0] ln, input logic [NC-1:0] exp_mask,
                           input logic [2:0] exp_snp, input logic reply_dirty, input logic [DW-1:0] reply_d,
                           input int hold, input logic [2:0] exp_kind, input logic [1:0] exp_dest,
                           input logic [DW-1:0] exp_data);
        logic [NC-1:0] seen, owe;
        bit got;
        int cyc;
        seen = '0; owe = '0; got = 0; cyc = 0;
        while (!got && cyc < 200) begin
            @(negedge clk);
            cyc++;
            out_ready = 1'b1;
            snp_valid = 1'b0;
            if (out_valid) begin
                if (out_kind >= K_INV) begin
                    chk(out_kind == exp_snp, {tag, " snoop kind"}, DW'(out_kind), DW'(exp_snp));
                    seen[out_dest] = 1'b1;
                    owe[out_dest] = 1'b1;
                end else begin
                    got = 1;
                    chk(owe == '0, {tag, " R5 grant before all replies"}, DW'(owe), '0);
                    chk(seen == exp_mask, {tag, " snoop targets"}, DW'(seen), DW'(exp_mask));
                    chk(out_kind == exp_kind, {tag, " grant kind"}, DW'(out_kind), DW'(exp_kind));
                    chk(out_dest == exp_dest && out_line == ln, {tag, " grant dest/line"},
                        DW'({out_dest, out_line}), DW'({exp_dest, ln}));
                    chk(out_data == exp_data, {tag, " grant data"}, out_data, exp_data);
                end
            end
            if (!got && cyc > hold && owe != '0) begin
                for (int i = NC - 1; i >= 0; i--) if (owe[i]) snp_src = 2'(i);
                owe[snp_src] = 1'b0;
                snp_valid = 1'b1;
                snp_has_data = reply_dirty;
                snp_data = reply_d;
            end
        end
        if (!got) chk(1'b0, {tag, " no grant"}, '0, 1);
        @(posedge clk);
        #1 out_ready = 1'b0;
        snp_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready after reset", DW'(req_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", DW'(out_valid), 0);
    endtask

    task automatic t_shared_fill();
        send_req(Q_SH, 4'd3, 2'd0, '0);
        collect("R1 R2 Un shared", 4'd3, 4'b0000, K_DWN, 0, 0, 0, K_SHG, 2'd0, 32'd3);
        send_req(Q_SH, 4'd3, 2'd2, '0);
        collect("R2 Sh shared", 4'd3, 4'b0000, K_DWN, 0, 0, 0, K_SHG, 2'd2, 32'd3);
    endtask

    task automatic t_upgrade_delayed();
        send_req(Q_EX, 4'd3, 2'd1, '0);
        collect("R4 R5 inval sharers delayed", 4'd3, 4'b0101, K_INV, 0, 0, 6, K_EXG, 2'd1, 32'd3);
    endtask

    task automatic t_downgrade();
        send_req(Q_SH, 4'd3, 2'd0, '0);
        collect("R3 downgrade owner", 4'd3, 4'b0010, K_DWN, 1, 32'hAB, 2, K_SHG, 2'd0, 32'hAB);
        send_req(Q_EX, 4'd3, 2'd0, '0);
        collect("R3 R4 inval other only", 4'd3, 4'b0010, K_INV, 0, 0, 0, K_EXG, 2'd0, 32'hAB);
    endtask

    task automatic t_wb_owner();
        send_req(Q_WB, 4'd3, 2'd0, 32'h55);
        collect("R7 owner writeback", 4'd3, 4'b0000, K_INV, 0, 0, 0, K_ACK, 2'd0, 32'd0);
        send_req(Q_SH, 4'd3, 2'd2, '0);
        collect("R7 line uncached with new data", 4'd3, 4'b0000, K_DWN, 0, 0, 0, K_SHG, 2'd2, 32'h55);
    endtask

    task automatic t_wb_sharer();
        send_req(Q_SH, 4'd3, 2'd3, '0);
        collect("R2 add sharer", 4'd3, 4'b0000, K_DWN, 0, 0, 0, K_SHG, 2'd3, 32'h55);
        send_req(Q_WB, 4'd3, 2'd2, 32'h1);
        collect("R6 sharer writeback ack", 4'd3, 4'b0000, K_INV, 0, 0, 0, K_ACK, 2'd2, 32'd0);
        send_req(Q_EX, 4'd3, 2'd1, '0);
        collect("R6 sharer removed, memory kept", 4'd3, 4'b1000, K_INV, 0, 0, 0, K_EXG, 2'd1, 32'h55);
        send_req(Q_WB, 4'd3, 2'd1, 32'h77);
        collect("R7 owner writeback 2", 4'd3, 4'b0000, K_INV, 0, 0, 0, K_ACK, 2'd1, 32'd0);
        send_req(Q_SH, 4'd3, 2'd0, '0);
        collect("R7 data from writeback", 4'd3, 4'b0000, K_DWN, 0, 0, 0, K_SHG, 2'd0, 32'h77);
        send_req(Q_WB, 4'd3, 2'd0, 32'h2);
        collect("R6 last sharer writeback", 4'd3, 4'b0000, K_INV, 0, 0, 0, K_ACK, 2'd0, 32'd0);
        send_req(Q_EX, 4'd3, 2'd2, '0);
        collect("R6 line back to uncached", 4'd3, 4'b0000, K_INV, 0, 0, 0, K_EXG, 2'd2, 32'h77);
    endtask

    task automatic t_queued();
        send_req(Q_SH, 4'd5, 2'd0, '0);
        collect("R1 R2 line 5 fill", 4'd5, 4'b0000, K_DWN, 0, 0, 0, K_SHG, 2'd0, 32'd5);
        send_req(Q_EX, 4'd5, 2'd1, '0);
        send_req(Q_SH, 4'd5, 2'd2, '0);
        chk(req_ready == 1'b1, "R9 ready while busy", DW'(req_ready), 1);
        collect("R9 R5 first queued", 4'd5, 4'b0001, K_INV, 0, 0, 4, K_EXG, 2'd1, 32'd5);
        collect("R9 R3 second queued", 4'd5, 4'b0010, K_DWN, 1, 32'h99, 0, K_SHG, 2'd2, 32'h99);
    endtask

    task automatic t_stale_wb();
        send_req(Q_WB, 4'd5, 2'd3, 32'hDEAD);
        collect("R8 stale writeback ack", 4'd5, 4'b0000, K_INV, 0, 0, 0, K_ACK, 2'd3, 32'd0);
        send_req(Q_EX, 4'd5, 2'd0, '0);
        collect("R8 entry and memory unchanged", 4'd5, 4'b0110, K_INV, 0, 0, 0, K_EXG, 2'd0, 32'h99);
        send_req(Q_EX, 4'd5, 2'd3, '0);
        collect("R4 owner returns dirty data", 4'd5, 4'b0001, K_INV, 1, 32'h42, 1, K_EXG, 2'd3, 32'h42);
    endtask

    task automatic t_backpressure();
        logic [2:0] k0;
        logic [1:0] d0;
        send_req(Q_EX, 4'd5, 2'd2, '0);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R10 message pending", DW'(out_valid), 1);
        k0 = out_kind; d0 = out_dest;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid && out_kind == k0 && out_dest == d0, "R10 held under back-pressure",
                DW'({out_valid, out_kind, out_dest}), DW'({1'b1, k0, d0}));
        end
        collect("R10 R4 after stall", 4'd5, 4'b1000, K_INV, 1, 32'h43, 0, K_EXG, 2'd2, 32'h43);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_shared_fill();
        t_upgrade_delayed();
        t_downgrade();
        t_wb_owner();
        t_wb_sharer();
        t_queued();
        t_stale_wb();
        t_backpressure();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule